// File: doc/BRIEF.md
# Serial Programming Front End for a Fractional-N Synthesizer

This block turns a three-wire serial stream into the divider and fractional settings of a frequency synthesizer. The wires are a shift clock, a data line and a load strobe. A fourth line, the option enable, selects a separate control register. Every serial line is brought into the system clock domain through a two-flop synchronizer. Edges of the shift clock, the strobe and the option enable are then detected on that clock.

Normal frames are 21 bits long. They enter one shared primary shift register, first bit first. The strobe's rising edge copies the frame to one of two holding registers. The last bit of the frame picks which one: the divider register (reference divide R, main divide M, swallow count A, prescaler bypass) or the 18-bit fractional word K. A short 8-bit option frame uses its own shift path. It is committed to a shadow copy when the option enable falls, and it reaches the outputs only while an active-low gate input is held low. A direct-mode input replaces every divider and fractional field with parallel pin values and leaves the serial registers untouched.

Top module: `pll_serial_cfg`

## Requirements
- R1: After reset, with direct mode low, `div_r`, `div_m`, `div_a`, `pre_bypass`, `frac_k` and `opt_ctrl` are all zero.
- R2: Each rising edge of `sclk_in`, while both `opt_en_in` and `latch_in` are low, shifts `sdata_in` into a 21-bit primary register. The first bit received is frame bit B0 and the 21st is B20.
- R3: A rising edge of `latch_in` with B20 = 0 loads the divider register. B0 and B1 give R bits 5 and 4. B2 and B3 give M bits 8 and 7. B4 gives `pre_bypass`. B5..B11 give M bits 6..0. B12..B15 give R bits 3..0. B16..B19 give A bits 3..0.
- R4: A rising edge of `latch_in` with B20 = 1 loads K, with B0..B17 giving K bits 17..0. B18 and B19 are discarded.
- R5: A load of either holding register leaves the other unchanged. Both hold their value between loads.
- R6: While `opt_en_in` is high, each rising edge of `sclk_in` shifts `sdata_in` into an 8-bit option register. Of the last eight bits received, the first becomes option bit 0 and the last becomes bit 7. Bit meanings (all active high): 0 and 1 reserved, 2 route the main divider output to the data-out pin, 3 power down, 4 continuous counter load, 5 route the modulus select to the data-out pin, 6 route the reference divider output to the data-out pin, 7 disable lock detect.
- R7: `opt_ctrl` takes a new value only after a falling edge of `opt_en_in`. Bits shifted in while the enable is high do not appear before that edge.
- R8: `opt_ctrl` shows the committed option bits only while `opt_gate_n_in` is low. When the gate is high the output is all zero, and the committed bits are kept.
- R9: While `direct_in` is high, `div_r`, `div_m`, `div_a`, `pre_bypass` and `frac_k` follow `pin_r`, `pin_m`, `pin_a`, `pin_pre_bypass` and `pin_k`. When it goes low, the serially loaded values reappear unchanged.
- R10: A rising edge of `latch_in` while `opt_en_in` is high changes neither holding register.
- R11: Rising edges of `sclk_in` while `opt_en_in` is high leave the primary register unchanged. A later strobe still loads the frame shifted in before the option frame.
- R12: If `latch_in` rises between clock edges e0 and e1, the holding register changes at rising clock edge e3 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_in | input | 1 | Serial shift clock (asynchronous) |
| sdata_in | input | 1 | Serial data, first bit first |
| latch_in | input | 1 | Load strobe; rising edge commits the primary frame |
| opt_en_in | input | 1 | Option enable; high shifts the option frame, falling edge commits it |
| direct_in | input | 1 | High selects parallel pin values for divider and fractional outputs |
| opt_gate_n_in | input | 1 | Active-low gate for the option outputs |
| pin_r | input | 6 | Parallel reference divide value |
| pin_m | input | 9 | Parallel main divide value |
| pin_a | input | 4 | Parallel swallow count |
| pin_pre_bypass | input | 1 | Parallel prescaler bypass |
| pin_k | input | 18 | Parallel fractional word |
| div_r | output | 6 | Reference divide field |
| div_m | output | 9 | Main divide field |
| div_a | output | 4 | Swallow count field |
| pre_bypass | output | 1 | Prescaler bypass, 1 = bypassed |
| frac_k | output | 18 | Fractional word |
| opt_ctrl | output | 8 | Gated option control bits |

## Verification
The hardest case to reach from the ports is a frame left in the primary register without a strobe, which then has to survive an option frame and a strobe issued while the option enable is high. The stimulus shifts a second divider frame, raises the option enable, shifts eight option bits and pulses the strobe inside that window. The divider outputs must still show the first frame. A later strobe with the enable low must then load the parked frame. The same strobe is also used to sample the outputs on each clock and pin down the cycle in which the register changes.

// File: rtl/pll_cfg_pkg.sv
// Package: shared widths, divider field record and frame unpacking helpers
// for the synthesizer serial programming front end.
// Assumes a 21-bit frame held with first-received bit B0 at index 20.
package pll_cfg_pkg;

    parameter int PRIM_W = 21;
    parameter int OPT_W  = 8;
    parameter int R_W    = 6;
    parameter int M_W    = 9;
    parameter int A_W    = 4;
    parameter int K_W    = 18;

    localparam int ADDR_BIT = 0;
    localparam int K_LSB    = PRIM_W - K_W;

    typedef struct packed {
        logic [R_W-1:0] r;
        logic [M_W-1:0] m;
        logic [A_W-1:0] a;
        logic           pre;
    } div_fields_t;

    // Split a divider frame; bit index = 20 - Bn.
    function automatic div_fields_t div_of(input logic [PRIM_W-1:0] f);
        div_fields_t d;
        d.r   = {f[20], f[19], f[8:5]};
        d.m   = {f[18], f[17], f[15:9]};
        d.pre = f[16];
        d.a   = f[4:1];
        return d;
    endfunction

    // Take the fractional word from the top of the frame.
    function automatic logic [K_W-1:0] frac_of(input logic [PRIM_W-1:0] f);
        return f[PRIM_W-1:K_LSB];
    endfunction

endpackage

// File: rtl/pll_cfg_sync.sv
// Module: two-flop synchronizer plus one delay stage per channel, giving
// synchronized levels and single-cycle rise and fall pulses.
// Assumes each input channel is an asynchronous, slowly toggling level.
module pll_cfg_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] meta_q, sync_q, prev_q;

    // Capture, settle and delay each channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Edge pulses per channel.
    for (genvar i = 0; i < W; i++) begin : g_edge
        assign rise[i] =  sync_q[i] & ~prev_q[i];
        assign fall[i] = ~sync_q[i] &  prev_q[i];
    end

    assign lvl = sync_q;

endmodule

// File: rtl/pll_cfg_shift.sv
// Module: enabled serial-in shift register. MSB_FIRST=1 inserts at bit 0 so
// the first bit ends at the top; MSB_FIRST=0 inserts at the top so the first
// bit ends at bit 0. Assumes shift_en is a single-cycle pulse per bit.
module pll_cfg_shift #(
    parameter int W         = 21,
    parameter bit MSB_FIRST = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] q
);
    logic [W-1:0] nxt;

    // Pick the insertion end.
    if (MSB_FIRST) begin : g_left
        assign nxt = {q[W-2:0], bit_in};
    end else begin : g_right
        assign nxt = {bit_in, q[W-1:1]};
    end

    // Advance one place per enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= '0;
        else if (shift_en) q <= nxt;
    end

    p_shift_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(q))
        else $error("shift register moved without an enable");

endmodule

// File: rtl/pll_cfg_optreg.sv
// Module: option control register with its own shift path, a shadow copy
// committed on request and an active-low output gate.
// Assumes commit is a single-cycle pulse from the enable's falling edge.
module pll_cfg_optreg
    import pll_cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             bit_in,
    input  logic             commit,
    input  logic             gate_n,
    output logic [OPT_W-1:0] ctrl
);
    logic [OPT_W-1:0] shadow_q, held_q;

    pll_cfg_shift #(.W(OPT_W), .MSB_FIRST(1'b0)) u_opt_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .bit_in   (bit_in),
        .q        (shadow_q)
    );

    // Copy the shifted bits into the held copy on commit.
    always_ff @(posedge clk) begin
        if (!rst_n)      held_q <= '0;
        else if (commit) held_q <= shadow_q;
    end

    assign ctrl = gate_n ? '0 : held_q;

    p_commit_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(held_q))
        else $error("option copy changed without commit");

    p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        gate_n |-> (ctrl == '0))
        else $error("option bits visible while gated");

endmodule

// File: rtl/pll_serial_cfg.sv
// Module: top of the serial programming front end. Synchronizes the serial
// lines, fills the shared primary frame, steers it on the strobe by its
// address bit, runs the option register and muxes in direct-mode pins.
// Assumes direct_in, opt_gate_n_in and the pin_* buses are quasi-static.
module pll_serial_cfg
    import pll_cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_in,
    input  logic             sdata_in,
    input  logic             latch_in,
    input  logic             opt_en_in,
    input  logic             direct_in,
    input  logic             opt_gate_n_in,
    input  logic [R_W-1:0]   pin_r,
    input  logic [M_W-1:0]   pin_m,
    input  logic [A_W-1:0]   pin_a,
    input  logic             pin_pre_bypass,
    input  logic [K_W-1:0]   pin_k,
    output logic [R_W-1:0]   div_r,
    output logic [M_W-1:0]   div_m,
    output logic [A_W-1:0]   div_a,
    output logic             pre_bypass,
    output logic [K_W-1:0]   frac_k,
    output logic [OPT_W-1:0] opt_ctrl
);
    localparam int CH_SCLK  = 0;
    localparam int CH_DATA  = 1;
    localparam int CH_LATCH = 2;
    localparam int CH_OPT   = 3;
    localparam int CH_N     = 4;

    logic [CH_N-1:0] raw, lvl, rise, fall;
    logic            sclk_rise, latch_rise, opt_lvl, opt_fall, bit_s;
    logic            prim_shift, load_stb, to_frac;
    logic [PRIM_W-1:0] prim_q;
    div_fields_t     div_q, div_sel;
    logic [K_W-1:0]  k_q;
    logic            unused_edges;

    assign raw = {opt_en_in, latch_in, sdata_in, sclk_in};

    pll_cfg_sync #(.W(CH_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw),
        .lvl   (lvl),
        .rise  (rise),
        .fall  (fall)
    );

    assign sclk_rise  = rise[CH_SCLK];
    assign latch_rise = rise[CH_LATCH];
    assign opt_lvl    = lvl[CH_OPT];
    assign opt_fall   = fall[CH_OPT];
    assign bit_s      = lvl[CH_DATA];
    assign unused_edges = &{1'b0, lvl[CH_SCLK], lvl[CH_LATCH], rise[CH_DATA],
                            rise[CH_OPT], fall[CH_SCLK], fall[CH_DATA], fall[CH_LATCH]};

    assign prim_shift = sclk_rise & ~opt_lvl & ~lvl[CH_LATCH];
    assign load_stb   = latch_rise & ~opt_lvl;
    assign to_frac    = prim_q[ADDR_BIT];

    pll_cfg_shift #(.W(PRIM_W), .MSB_FIRST(1'b1)) u_prim_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (prim_shift),
        .bit_in   (bit_s),
        .q        (prim_q)
    );

    // Steer the frame into the divider or fractional holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            k_q   <= '0;
        end else if (load_stb) begin
            if (to_frac) k_q   <= frac_of(prim_q);
            else         div_q <= div_of(prim_q);
        end
    end

    pll_cfg_optreg u_optreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (sclk_rise & opt_lvl),
        .bit_in   (bit_s),
        .commit   (opt_fall),
        .gate_n   (opt_gate_n_in),
        .ctrl     (opt_ctrl)
    );

    // Choose pin or serial values for the divider fields.
    always_comb begin
        div_sel = div_q;
        if (direct_in) begin
            div_sel.r   = pin_r;
            div_sel.m   = pin_m;
            div_sel.a   = pin_a;
            div_sel.pre = pin_pre_bypass;
        end
    end

    assign div_r      = div_sel.r;
    assign div_m      = div_sel.m;
    assign div_a      = div_sel.a;
    assign pre_bypass = div_sel.pre;
    assign frac_k     = direct_in ? pin_k : k_q;

    p_div_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_stb && !to_frac) |=> $stable(div_q))
        else $error("divider register changed without a divider load");

    p_k_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_stb && to_frac) |=> $stable(k_q))
        else $error("fractional register changed without a fractional load");

    p_strobe_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_rise && opt_lvl) |=> ($stable(div_q) && $stable(k_q)))
        else $error("strobe acted while option enable high");

endmodule

// File: tb/pll_serial_cfg_bench.sv
`timescale 1ns/1ps
module pll_serial_cfg_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk_in = 1'b0, sdata_in = 1'b0, latch_in = 1'b0, opt_en_in = 1'b0;
    logic direct_in = 1'b0, opt_gate_n_in = 1'b0;
    logic [5:0]  pin_r = '0;
    logic [8:0]  pin_m = '0;
    logic [3:0]  pin_a = '0;
    logic        pin_pre_bypass = 1'b0;
    logic [17:0] pin_k = '0;
    logic [5:0]  div_r;
    logic [8:0]  div_m;
    logic [3:0]  div_a;
    logic        pre_bypass;
    logic [17:0] frac_k;
    logic [7:0]  opt_ctrl;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pll_serial_cfg u_pll_serial_cfg (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .sdata_in(sdata_in),
        .latch_in(latch_in), .opt_en_in(opt_en_in), .direct_in(direct_in),
        .opt_gate_n_in(opt_gate_n_in), .pin_r(pin_r), .pin_m(pin_m), .pin_a(pin_a),
        .pin_pre_bypass(pin_pre_bypass), .pin_k(pin_k), .div_r(div_r), .div_m(div_m),
        .div_a(div_a), .pre_bypass(pre_bypass), .frac_k(frac_k), .opt_ctrl(opt_ctrl)
    );

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit pq[$];
    bit oq[$];
    logic [3:0]  h1, h2, h3;   // {opt, latch, data, sclk} seen 1,2,3 edges ago
    logic [5:0]  mr;
    logic [8:0]  mm;
    logic [3:0]  ma;
    logic        mp;
    logic [17:0] mk;
    logic [7:0]  mo;

    always @(posedge clk) begin
        if (!rst_n) begin
            pq.delete(); oq.delete();
            for (int i = 0; i < 21; i++) pq.push_back(1'b0);
            for (int i = 0; i < 8; i++)  oq.push_back(1'b0);
            h1 = '0; h2 = '0; h3 = '0;
            mr = '0; mm = '0; ma = '0; mp = 1'b0; mk = '0; mo = '0;
        end else begin
            if (h3[3] && !h2[3])
                for (int i = 0; i < 8; i++) mo[i] = oq[i];
            if (h2[2] && !h3[2] && !h2[3]) begin
                if (pq[20]) begin
                    for (int j = 0; j < 18; j++) mk[17-j] = pq[j];
                end else begin
                    mr[5] = pq[0]; mr[4] = pq[1]; mm[8] = pq[2]; mm[7] = pq[3]; mp = pq[4];
                    for (int j = 0; j < 7; j++) mm[6-j] = pq[5+j];
                    for (int j = 0; j < 4; j++) mr[3-j] = pq[12+j];
                    for (int j = 0; j < 4; j++) ma[3-j] = pq[16+j];
                end
            end
            if (h2[0] && !h3[0]) begin
                if (h2[3]) begin
                    oq.push_back(h2[1]); void'(oq.pop_front());
                end else if (!h2[2]) begin
                    pq.push_back(h2[1]); void'(pq.pop_front());
                end
            end
            h3 = h2; h2 = h1; h1 = {opt_en_in, latch_in, sdata_in, sclk_in};
        end
    end

    // Compare every output against the model away from the clock edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            cmp("R3 R9 model div_r", div_r, direct_in ? pin_r : mr);
            cmp("R3 R9 model div_m", div_m, direct_in ? pin_m : mm);
            cmp("R3 R9 model div_a", div_a, direct_in ? pin_a : ma);
            cmp("R3 R9 model pre_bypass", pre_bypass, direct_in ? pin_pre_bypass : mp);
            cmp("R4 R9 model frac_k", frac_k, direct_in ? pin_k : mk);
            cmp("R6 R8 model opt_ctrl", opt_ctrl, opt_gate_n_in ? 8'h00 : mo);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_bit(input logic b);
        sdata_in = b; idle(3);
        sclk_in = 1'b1; idle(4);
        sclk_in = 1'b0; idle(1);
    endtask

    task automatic send_frame(input logic [20:0] f);
        for (int i = 20; i >= 0; i--) send_bit(f[i]);
    endtask

    task automatic pulse_latch();
        latch_in = 1'b1; idle(6);
        latch_in = 1'b0; idle(6);
    endtask

    function automatic logic [20:0] div_frame(input logic [5:0] r, input logic [8:0] m,
                                              input logic [3:0] a, input logic p);
        return {r[5], r[4], m[8], m[7], p, m[6:0], r[3:0], a, 1'b0};
    endfunction

    task automatic sample(input string tag, input logic [31:0] act_sel, input logic [31:0] exp);
        cmp(tag, act_sel, exp);
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);
        @(negedge clk);
        sample("R1 div_r", div_r, 0);   sample("R1 div_m", div_m, 0);
        sample("R1 div_a", div_a, 0);   sample("R1 pre_bypass", pre_bypass, 0);
        sample("R1 frac_k", frac_k, 0); sample("R1 opt_ctrl", opt_ctrl, 0);
        idle(1);

        send_frame(div_frame(6'h2B, 9'h1A5, 4'hA, 1'b1));
        pulse_latch();
        @(negedge clk);
        sample("R2 first bit in R msb", div_r[5], 1);
        sample("R3 div_r", div_r, 6'h2B);   sample("R3 div_m", div_m, 9'h1A5);
        sample("R3 div_a", div_a, 4'hA);    sample("R3 pre_bypass", pre_bypass, 1);
        sample("R5 frac_k untouched", frac_k, 0);
        idle(1);

        send_frame({18'h25A3C, 2'b11, 1'b1});
        pulse_latch();
        @(negedge clk);
        sample("R4 frac_k", frac_k, 18'h25A3C);
        sample("R5 div_r untouched", div_r, 6'h2B);
        idle(1);

        // Park a second divider frame, then run an option frame over it.
        send_frame(div_frame(6'h15, 9'h0C3, 4'h3, 1'b0));
        opt_en_in = 1'b1; idle(4);
        begin
            logic [7:0] ov = 8'b1011_0100;
            for (int i = 0; i < 8; i++) send_bit(ov[i]);
        end
        pulse_latch();
        @(negedge clk);
        sample("R10 div_r after masked strobe", div_r, 6'h2B);
        sample("R10 frac_k after masked strobe", frac_k, 18'h25A3C);
        sample("R7 opt_ctrl before commit", opt_ctrl, 0);
        idle(1);
        opt_en_in = 1'b0; idle(6);
        @(negedge clk);
        sample("R6 opt_ctrl committed", opt_ctrl, 8'b1011_0100);
        idle(1);
        opt_gate_n_in = 1'b1; idle(1);
        @(negedge clk);
        sample("R8 opt_ctrl gated", opt_ctrl, 0);
        idle(1);
        opt_gate_n_in = 1'b0; idle(1);
        @(negedge clk);
        sample("R8 opt_ctrl kept", opt_ctrl, 8'b1011_0100);
        idle(1);

        // Strobe latency and loading of the parked frame.
        latch_in = 1'b1;
        @(negedge clk); @(negedge clk); @(negedge clk);
        sample("R12 no change before third edge", div_r, 6'h2B);
        @(negedge clk);
        sample("R12 change at third edge", div_r, 6'h15);
        sample("R11 parked frame div_m", div_m, 9'h0C3);
        sample("R11 parked frame div_a", div_a, 4'h3);
        idle(1);
        latch_in = 1'b0; idle(6);

        // Direct mode.
        pin_r = 6'h3A; pin_m = 9'h155; pin_a = 4'h6; pin_pre_bypass = 1'b1; pin_k = 18'h1F00F;
        direct_in = 1'b1; idle(1);
        @(negedge clk);
        sample("R9 direct div_r", div_r, 6'h3A);     sample("R9 direct div_m", div_m, 9'h155);
        sample("R9 direct div_a", div_a, 4'h6);      sample("R9 direct pre", pre_bypass, 1);
        sample("R9 direct frac_k", frac_k, 18'h1F00F);
        idle(1);
        direct_in = 1'b0; idle(1);
        @(negedge clk);
        sample("R9 serial div_r restored", div_r, 6'h15);
        sample("R9 serial frac_k restored", frac_k, 18'h25A3C);
        idle(2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // Watchdog.
    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule